// File: doc/BRIEF.md
# Digital PLL lock detector

This block watches the up and down pulses of a phase-frequency detector and drives a digital lock flag. The two pulses are combined with a logical OR. Only one combined pulse in every `SAMPLE_DIV` (32 by default) is measured. Its width is the number of rising edges of the fast sampling clock at which the combined signal is high. Widths are counted in sampling-clock cycles, so the thresholds are parameters in cycles: 14, 6 and 22 at a 1 GHz sampling clock.

While the flag is low, the block counts measured pulses that are narrower than the active assert threshold. A precision input selects the coarse threshold or the fine threshold. After `PASS_NEED` (five) such pulses in a row, the flag rises. Once the flag is high, only a measured pulse wider than the release threshold clears it. Pulses between the two thresholds leave it alone, which gives the flag hysteresis. A divider-register write or a power-down clears the flag, and the pulse selector and pass counter restart from zero.

Top module: `pll_lock_detect`

## Requirements
- R1: The measured signal is `pfd_up | pfd_dn`; a pulse carried only on the down input, or split across both inputs with overlap, is measured as the width of the OR.
- R2: Only the first combined pulse after reset or clear, and every 32nd one after it, is measured; the other pulses, however wide, have no effect on `locked`.
- R3: With `fine_prec` = 0, `locked` rises after five consecutive measured pulses of width below 14 cycles; a width of 13 passes.
- R4: With `fine_prec` = 1, the pass condition is width below 6 cycles; widths of 5 pass and widths of 6 or 10 fail.
- R5: While `locked` is 1, a measured pulse of width up to and including 22 cycles leaves `locked` at 1, even if it fails the assert threshold.
- R6: While `locked` is 1, a measured pulse wider than 22 cycles clears `locked`.
- R7: While `locked` is 0, a measured pulse that fails the active assert threshold resets the consecutive-pass count to zero.
- R8: A one-cycle `div_write` clears `locked` on the next edge and restarts both the 1-in-32 pulse counter and the pass counter from zero.
- R9: While `pwr_down` is 1, `locked` stays 0 and no pulse is counted; after it falls, locking starts again from zero counts.
- R10: A combined pulse still high after 23 samples is treated as wider than 22 cycles at that moment, without waiting for its falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pfd_up | input | 1 | Phase detector up pulse |
| pfd_dn | input | 1 | Phase detector down pulse |
| fine_prec | input | 1 | 1 selects the fine assert threshold, 0 the coarse one |
| div_write | input | 1 | One-cycle strobe marking a divider-register write |
| pwr_down | input | 1 | Power-down level; holds the detector cleared |
| locked | output | 1 | Digital lock indication |

## Verification
Each measured pulse is followed by 31 filler pulses that are wider than the release threshold. A lock that survives these fillers shows that unmeasured pulses are ignored. A selector that is out of step after a clear would measure a filler and never lock. Measured pulses are driven on the up input only, on the down input only, or split across both with an overlap. Their widths sit on each side of each threshold: 13/14, 5/6, 22/23. This separates the strict-less-than assert test from the inclusive release test, and the coarse threshold from the fine one. A pass streak is broken by one failing pulse, and another is interrupted by a divider write, so a counter that does not reset shows up as an early lock. Holding the combined input high shows that lock drops at saturation while the pulse is still high.

// File: rtl/pll_lockdet_pkg.sv
package pll_lockdet_pkg;

    localparam int unsigned MW = 8;

    typedef struct packed {
        logic          valid;
        logic [MW-1:0] width;
    } meas_t;

    typedef enum logic [1:0] {
        V_NARROW = 2'd0,
        V_MID    = 2'd1,
        V_WIDE   = 2'd2
    } verdict_t;

    function automatic verdict_t classify(
        input logic [MW-1:0] width,
        input logic [MW-1:0] assert_thr,
        input logic [MW-1:0] release_thr
    );
        if (width < assert_thr)
            return V_NARROW;
        else if (width > release_thr)
            return V_WIDE;
        else
            return V_MID;
    endfunction

endpackage

// File: rtl/lkd_pulse_meter.sv
module lkd_pulse_meter
    import pll_lockdet_pkg::*;
#(
    parameter int SAMPLE_DIV = 32,
    parameter int SAT_CNT    = 23
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  up,
    input  logic  dn,
    output meas_t meas
);
    localparam int IW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

    logic          comb_now;
    logic          comb_q;
    logic          busy;
    logic [IW-1:0] idx;
    logic [MW-1:0] cnt;

    assign comb_now = up | dn;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            comb_q <= 1'b0;
            busy   <= 1'b0;
            idx    <= '0;
            cnt    <= '0;
            meas   <= '0;
        end else begin
            meas.valid <= 1'b0;
            comb_q     <= comb_now;
            if (comb_now && !comb_q) begin
                idx <= (idx == IW'(SAMPLE_DIV - 1)) ? '0 : idx + 1'b1;
                if (idx == '0) begin
                    busy <= 1'b1;
                    cnt  <= MW'(1);
                end
            end else if (busy) begin
                if (!comb_now) begin
                    busy <= 1'b0;
                    meas <= '{valid: 1'b1, width: cnt};
                end else if (cnt == MW'(SAT_CNT - 1)) begin
                    busy <= 1'b0;
                    meas <= '{valid: 1'b1, width: MW'(SAT_CNT)};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_width_range_r10: assert property (@(posedge clk) disable iff (rst)
        meas.valid |-> (meas.width >= MW'(1) && meas.width <= MW'(SAT_CNT)));

    p_single_result_r2: assert property (@(posedge clk) disable iff (rst)
        meas.valid |=> !meas.valid);

    p_clear_idle_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!busy && idx == '0 && !meas.valid));

endmodule

// File: rtl/lkd_lock_ctrl.sv
module lkd_lock_ctrl
    import pll_lockdet_pkg::*;
#(
    parameter int PASS_NEED   = 5,
    parameter int THR_COARSE  = 14,
    parameter int THR_FINE    = 6,
    parameter int THR_RELEASE = 22
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  fine,
    input  meas_t meas,
    output logic  locked
);
    localparam int PW = $clog2(PASS_NEED + 1);

    logic [PW-1:0] pass_cnt;
    logic [MW-1:0] assert_thr;
    verdict_t      verdict;

    assign assert_thr = fine ? MW'(THR_FINE) : MW'(THR_COARSE);
    assign verdict    = classify(meas.width, assert_thr, MW'(THR_RELEASE));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            locked   <= 1'b0;
            pass_cnt <= '0;
        end else if (meas.valid) begin
            if (locked) begin
                if (verdict == V_WIDE)
                    locked <= 1'b0;
            end else if (verdict == V_NARROW) begin
                if (pass_cnt == PW'(PASS_NEED - 1)) begin
                    locked   <= 1'b1;
                    pass_cnt <= '0;
                end else begin
                    pass_cnt <= pass_cnt + 1'b1;
                end
            end else begin
                pass_cnt <= '0;
            end
        end
    end

    p_hold_mid_r5: assert property (@(posedge clk) disable iff (rst)
        (locked && meas.valid && meas.width <= MW'(THR_RELEASE) && !clr) |=> locked);

    p_release_wide_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && meas.valid && meas.width > MW'(THR_RELEASE) && !clr) |=> !locked);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !locked);

    p_rise_on_result_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(meas.valid));

    p_fail_resets_r7: assert property (@(posedge clk) disable iff (rst)
        (!locked && meas.valid && meas.width >= assert_thr && !clr) |=> (pass_cnt == '0 && !locked));

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_lockdet_pkg::*;
#(
    parameter int SAMPLE_DIV  = 32,
    parameter int PASS_NEED   = 5,
    parameter int THR_COARSE  = 14,
    parameter int THR_FINE    = 6,
    parameter int THR_RELEASE = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic pfd_up,
    input  logic pfd_dn,
    input  logic fine_prec,
    input  logic div_write,
    input  logic pwr_down,
    output logic locked
);
    logic  clr;
    meas_t meas;

    assign clr = div_write | pwr_down;

    lkd_pulse_meter #(
        .SAMPLE_DIV (SAMPLE_DIV),
        .SAT_CNT    (THR_RELEASE + 1)
    ) u_meter (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .up   (pfd_up),
        .dn   (pfd_dn),
        .meas (meas)
    );

    lkd_lock_ctrl #(
        .PASS_NEED   (PASS_NEED),
        .THR_COARSE  (THR_COARSE),
        .THR_FINE    (THR_FINE),
        .THR_RELEASE (THR_RELEASE)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .fine   (fine_prec),
        .meas   (meas),
        .locked (locked)
    );

    p_powerdown_low_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && $past(pwr_down)) |-> !locked);

endmodule

// File: tb/tb_pll_lock_detect.sv
`timescale 1ns/1ps
module tb_pll_lock_detect;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pfd_up = 1'b0;
    logic pfd_dn = 1'b0;
    logic fine_prec = 1'b0;
    logic div_write = 1'b0;
    logic pwr_down = 1'b0;
    logic locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pll_lock_detect dut (
        .clk       (clk),
        .rst       (rst),
        .pfd_up    (pfd_up),
        .pfd_dn    (pfd_dn),
        .fine_prec (fine_prec),
        .div_write (div_write),
        .pwr_down  (pwr_down),
        .locked    (locked)
    );

    // {fine_prec, drive mode (0 up, 1 down, 2 split), width, expected locked}
    localparam int NV = 18;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'd10, 1'b0},
        {1'b0, 2'd1, 8'd10, 1'b0},
        {1'b0, 2'd2, 8'd13, 1'b0},
        {1'b0, 2'd0, 8'd10, 1'b0},
        {1'b0, 2'd1, 8'd10, 1'b1},
        {1'b0, 2'd0, 8'd20, 1'b1},
        {1'b0, 2'd2, 8'd22, 1'b1},
        {1'b0, 2'd0, 8'd23, 1'b0},
        {1'b1, 2'd0, 8'd10, 1'b0},
        {1'b1, 2'd0, 8'd5,  1'b0},
        {1'b1, 2'd1, 8'd5,  1'b0},
        {1'b1, 2'd0, 8'd6,  1'b0},
        {1'b1, 2'd0, 8'd5,  1'b0},
        {1'b1, 2'd2, 8'd5,  1'b0},
        {1'b1, 2'd0, 8'd5,  1'b0},
        {1'b1, 2'd1, 8'd5,  1'b0},
        {1'b1, 2'd2, 8'd5,  1'b1},
        {1'b1, 2'd0, 8'd14, 1'b1}
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: locked=%0b expected %0b", req, got, exp);
        end
    endtask

    task automatic one_pulse(input int w, input int gap, input int mode);
        int h;
        h = (w + 1) / 2;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            case (mode)
                0: begin pfd_up = 1'b1; pfd_dn = 1'b0; end
                1: begin pfd_up = 1'b0; pfd_dn = 1'b1; end
                default: begin pfd_up = (i < h); pfd_dn = (i >= h - 1); end
            endcase
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            pfd_up = 1'b0;
            pfd_dn = 1'b0;
        end
    endtask

    task automatic fillers(input int n);
        for (int i = 0; i < n; i++) one_pulse(25, 2, 0);
    endtask

    task automatic group(input int w, input int mode);
        one_pulse(w, 3, mode);
        fillers(31);
    endtask

    task automatic strobe_div();
        @(negedge clk);
        div_write = 1'b1;
        @(negedge clk);
        div_write = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: locked=%0b expected run to finish", locked);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(locked, 1'b0, "reset state");

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int s = 0; s < NV; s++) begin
            fine_prec = VEC[s][11];
            group(int'(VEC[s][8:1]), int'(VEC[s][10:9]));
            check(locked, VEC[s][0], $sformatf("R1 R2 R3 R4 R5 R6 R7 step %0d", s));
        end

        // R8: clear on divider write
        strobe_div();
        check(locked, 1'b0, "R8 divider write clears lock");

        // R8: selector restart (misalign by 10 fillers, then clear)
        fine_prec = 1'b0;
        fillers(10);
        strobe_div();
        for (int g = 0; g < 4; g++) group(10, 0);
        strobe_div();
        group(10, 0);
        check(locked, 1'b0, "R8 pass counter restarted");
        for (int g = 0; g < 3; g++) group(10, 1);
        check(locked, 1'b0, "R8 four passes after clear");
        group(10, 2);
        check(locked, 1'b1, "R8 fifth pass after clear locks");

        // R3 boundary: width 14 fails coarse threshold
        strobe_div();
        for (int g = 0; g < 4; g++) group(10, 0);
        group(14, 0);
        check(locked, 1'b0, "R3 width 14 is not narrow");
        for (int g = 0; g < 5; g++) group(13, 0);
        check(locked, 1'b1, "R3 five width-13 pulses lock");

        // R9: power-down
        @(negedge clk);
        pwr_down = 1'b1;
        @(negedge clk);
        check(locked, 1'b0, "R9 power-down clears lock");
        for (int g = 0; g < 5; g++) group(10, 0);
        check(locked, 1'b0, "R9 no lock while powered down");
        pwr_down = 1'b0;
        for (int g = 0; g < 4; g++) group(10, 0);
        check(locked, 1'b0, "R9 restart needs five passes");
        group(10, 0);
        check(locked, 1'b1, "R9 lock after power-up");

        // R10: stuck-high combined pulse
        repeat (3) @(negedge clk);
        pfd_dn = 1'b1;
        repeat (20) @(negedge clk);
        check(locked, 1'b1, "R10 lock held at 20 samples");
        repeat (6) @(negedge clk);
        check(locked, 1'b0, "R10 saturation drops lock while high");
        repeat (10) @(negedge clk);
        pfd_dn = 1'b0;
        repeat (3) @(negedge clk);
        fillers(31);
        for (int g = 0; g < 5; g++) group(5, 2);
        check(locked, 1'b1, "R10 relock after saturated pulse");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule